// File: doc/BRIEF.md
# PHY control-register bridge

This block lets a host on a simple 32-bit register bus reach the 16-bit internal control-register space of a PHY. The host never talks to the PHY directly. It loads a value into a data-in register, then fires one of four trigger registers. Each trigger launches one step on the PHY side: capture an address, capture write data, perform a read, or perform a write. A full PHY write takes three steps (address, data, write). A full PHY read takes two steps (address, read), after which the result sits in a data-out register.

Each step raises a request toward the PHY, together with a step code and the data-in value that was current when the trigger fired. The request is held, with its code and data frozen, until the PHY acknowledges. While a step is outstanding, the trigger register that launched it reads 1, so the host can poll it. Every other trigger reads 0. A trigger that arrives while a step is outstanding is dropped. The bridge adds only one cycle of its own to each step, so completion time is set by the PHY's acknowledge latency. That keeps each step far inside a host polling budget of about ten polls spaced tens of microseconds apart.

PHY-side addresses for per-lane registers are formed by the host as a base plus 0x100 times the lane number. Lane 0 has its receive override at 0x1006 and its transmit drive override at 0x1002.

Top module: `phycr_bridge`

## Requirements
- R1: After synchronous reset, `cr_req` is low and every mapped register reads 0: data-in, data-out and all four triggers.
- R2: A write to offset 0x0C stores the low 16 bits of the write data as data-in. A later read of 0x0C returns them with bits 31:16 equal to zero.
- R3: A write with bit0 = 1 to a trigger while no step is outstanding starts a step. At the next clock edge `cr_req` rises, and `cr_wdata` carries the data-in value. `cr_op` carries the code for the trigger that fired:

  | Trigger offset | Step | `cr_op` |
  |---|---|---|
  | 0x14 | capture address | 0 |
  | 0x18 | capture data | 1 |
  | 0x1C | read | 2 |
  | 0x20 | write | 3 |

  A trigger write with bit0 = 0 starts nothing.
- R4: `cr_req`, `cr_op` and `cr_wdata` hold steady while `cr_ack` is low. `cr_req` falls at the edge that samples `cr_req` and `cr_ack` both high.
- R5: A trigger register reads 1 while the step it launched is outstanding. It reads 0 otherwise. A trigger other than the active one reads 0.
- R6: A trigger write made while a step is outstanding is ignored. This includes a write in the same cycle as the acknowledge. It launches no later step, and the PHY performs no access because of it.
- R7: When a read step is acknowledged, `cr_rdata` is stored as data-out, readable at 0x10. Data-out does not change at any other time.
- R8: `bus_rdata` is loaded one cycle after `bus_rd_en` and held while `bus_rd_en` is low. Offsets other than 0x0C, 0x10 and 0x14 to 0x20 read 0. Writes to those offsets, or to 0x10, change nothing.
- R9: `cr_wdata` keeps the value captured at the trigger even if data-in is rewritten while the step is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr_en | input | 1 | Register-bus write strobe |
| bus_rd_en | input | 1 | Register-bus read strobe |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | BUS_W | Register write data |
| bus_rdata | output | BUS_W | Register read data, valid the cycle after `bus_rd_en` |
| cr_req | output | 1 | PHY step request, held until acknowledged |
| cr_op | output | 2 | Step code: 0 address, 1 data, 2 read, 3 write |
| cr_wdata | output | CR_W | Address or data captured for the step |
| cr_ack | input | 1 | PHY acknowledge of the current step |
| cr_rdata | input | CR_W | PHY read result, sampled with the read acknowledge |

## Verification
The bench builds the block with its default parameters: a 32-bit bus, 6-bit offsets and 16-bit PHY words. With 6-bit offsets, every mapped offset is reachable, along with unmapped ones below and above them (0x00 and 0x3C). With 16-bit PHY words, the per-lane addresses 0x1002 and 0x1006 plus multiples of 0x100 can be used as real targets.

A register-array PHY model in the bench acknowledges after a latency that cycles from zero to three cycles, or that is forced to five or six cycles. The long latencies open a window for issuing stray triggers and rewriting data-in mid-step. The zero-cycle latency exercises an acknowledge in the very cycle after the request rises.

// File: rtl/phycr_pkg.sv
package phycr_pkg;
  localparam int OP_W = 2;

  // Step codes seen by the PHY; order follows the trigger offsets.
  localparam logic [OP_W-1:0] STEP_ADDR  = 2'd0;
  localparam logic [OP_W-1:0] STEP_DATA  = 2'd1;
  localparam logic [OP_W-1:0] STEP_READ  = 2'd2;
  localparam logic [OP_W-1:0] STEP_WRITE = 2'd3;

  // Register byte offsets.
  localparam int OFF_DIN    = 'h0C;
  localparam int OFF_DOUT   = 'h10;
  localparam int OFF_TRIG0  = 'h14;
  localparam int TRIG_STEP  = 4;
  localparam int NUM_TRIG   = 4;
endpackage

// File: rtl/phycr_host_regs.sv
module phycr_host_regs
  import phycr_pkg::*;
#(
  parameter int BUS_W  = 32,
  parameter int ADDR_W = 6,
  parameter int CR_W   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr_en,
  input  logic              bus_rd_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  input  logic              step_busy,
  input  logic [OP_W-1:0]   step_op,
  input  logic [CR_W-1:0]   dout,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic [CR_W-1:0]   din,
  output logic              start_vld,
  output logic [OP_W-1:0]   start_op
);
  localparam int PAD_W = BUS_W - CR_W;

  logic [NUM_TRIG-1:0] trig_hit;
  logic                hit_din;
  logic                hit_dout;
  logic [BUS_W-1:0]    rd_next;
  logic                unused_hi;

  assign unused_hi = ^bus_wdata[BUS_W-1:CR_W];
  assign hit_din   = (bus_addr == ADDR_W'(OFF_DIN));
  assign hit_dout  = (bus_addr == ADDR_W'(OFF_DOUT));

  for (genvar i = 0; i < NUM_TRIG; i++) begin : g_trig
    assign trig_hit[i] = (bus_addr == ADDR_W'(OFF_TRIG0 + TRIG_STEP * i));
  end

  assign start_vld = bus_wr_en && (|trig_hit) && bus_wdata[0];

  always_comb begin
    start_op = '0;
    for (int k = 0; k < NUM_TRIG; k++)
      if (trig_hit[k]) start_op = OP_W'(k);
  end

  always_comb begin
    rd_next = '0;
    if (hit_din)  rd_next = {{PAD_W{1'b0}}, din};
    if (hit_dout) rd_next = {{PAD_W{1'b0}}, dout};
    for (int k = 0; k < NUM_TRIG; k++)
      if (trig_hit[k]) rd_next = BUS_W'(step_busy && (step_op == OP_W'(k)));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      din       <= '0;
      bus_rdata <= '0;
    end else begin
      if (bus_wr_en && hit_din) din <= bus_wdata[CR_W-1:0];
      if (bus_rd_en) bus_rdata <= rd_next;
    end
  end

  // R8: read data only moves when a read is presented
  p_rdata_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !bus_rd_en |=> $stable(bus_rdata));

  // R2: data-in only moves on a write to its offset
  p_din_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr_en && hit_din) |=> $stable(din));
endmodule

// File: rtl/phycr_step_engine.sv
module phycr_step_engine
  import phycr_pkg::*;
#(
  parameter int CR_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start_vld,
  input  logic [OP_W-1:0] start_op,
  input  logic [CR_W-1:0] start_data,
  input  logic            ack,
  input  logic [CR_W-1:0] phy_rdata,
  output logic            req,
  output logic [OP_W-1:0] op,
  output logic [CR_W-1:0] wdata,
  output logic [CR_W-1:0] dout
);
  logic done;
  assign done = req && ack;

  always_ff @(posedge clk) begin
    if (rst) begin
      req   <= 1'b0;
      op    <= STEP_ADDR;
      wdata <= '0;
      dout  <= '0;
    end else if (done) begin
      req <= 1'b0;
      if (op == STEP_READ) dout <= phy_rdata;
    end else if (!req && start_vld) begin
      req   <= 1'b1;
      op    <= start_op;
      wdata <= start_data;
    end
  end

  // R4: request and its payload hold until acknowledged
  p_hold_req_r4: assert property (@(posedge clk) disable iff (rst)
    req && !ack |=> req && $stable(op) && $stable(wdata));

  // R4: request drops right after the acknowledge
  p_drop_after_ack_r4: assert property (@(posedge clk) disable iff (rst)
    req && ack |=> !req);

  // R7: data-out moves only on a read acknowledge
  p_dout_stable_r7: assert property (@(posedge clk) disable iff (rst)
    !(req && ack && op == STEP_READ) |=> $stable(dout));

  // R3/R6: a request only appears after a trigger seen while idle
  p_rise_needs_trigger_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(req) |-> $past(start_vld));
endmodule

// File: rtl/phycr_bridge.sv
module phycr_bridge
  import phycr_pkg::*;
#(
  parameter int BUS_W  = 32,
  parameter int ADDR_W = 6,
  parameter int CR_W   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr_en,
  input  logic              bus_rd_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              cr_req,
  output logic [1:0]        cr_op,
  output logic [CR_W-1:0]   cr_wdata,
  input  logic              cr_ack,
  input  logic [CR_W-1:0]   cr_rdata
);
  logic [CR_W-1:0] din;
  logic [CR_W-1:0] dout;
  logic            start_vld;
  logic [OP_W-1:0] start_op;

  phycr_host_regs #(.BUS_W(BUS_W), .ADDR_W(ADDR_W), .CR_W(CR_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .bus_wr_en (bus_wr_en),
    .bus_rd_en (bus_rd_en),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .step_busy (cr_req),
    .step_op   (cr_op),
    .dout      (dout),
    .bus_rdata (bus_rdata),
    .din       (din),
    .start_vld (start_vld),
    .start_op  (start_op)
  );

  phycr_step_engine #(.CR_W(CR_W)) u_engine (
    .clk        (clk),
    .rst        (rst),
    .start_vld  (start_vld),
    .start_op   (start_op),
    .start_data (din),
    .ack        (cr_ack),
    .phy_rdata  (cr_rdata),
    .req        (cr_req),
    .op         (cr_op),
    .wdata      (cr_wdata),
    .dout       (dout)
  );

  // R1: no request is pending straight out of reset
  p_idle_after_reset_r1: assert property (@(posedge clk)
    rst |=> !cr_req);
endmodule

// File: tb/phycr_bridge_tb_top.sv
module phycr_bridge_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr_en = 1'b0;
  logic        bus_rd_en = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        cr_req;
  logic [1:0]  cr_op;
  logic [15:0] cr_wdata;
  logic        cr_ack = 1'b0;
  logic [15:0] cr_rdata = '0;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  phycr_bridge dut_i (
    .clk(clk), .rst(rst), .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cr_req(cr_req), .cr_op(cr_op), .cr_wdata(cr_wdata),
    .cr_ack(cr_ack), .cr_rdata(cr_rdata)
  );

  // ---------------- PHY model: register array, varying ack latency
  logic [15:0] mem [int];
  logic [15:0] pa = '0;
  logic [15:0] pd = '0;
  int lat_force = -1;
  int nsteps = 0;
  int wcnt = 0;

  function automatic int cur_lat();
    return (lat_force >= 0) ? lat_force : (nsteps % 4);
  endfunction

  always @(negedge clk) begin
    if (cr_ack) begin
      cr_ack = 1'b0;
      wcnt = 0;
      nsteps++;
    end else if (cr_req && !rst) begin
      if (wcnt >= cur_lat()) begin
        cr_ack = 1'b1;
        case (cr_op)
          2'd0: pa = cr_wdata;
          2'd1: pd = cr_wdata;
          2'd2: cr_rdata = mem.exists(int'(pa)) ? mem[int'(pa)] : (pa ^ 16'h5A5A);
          default: mem[int'(pa)] = pd;
        endcase
      end else wcnt++;
    end
  end

  // ---------------- Behavioural reference model
  logic        m_req;
  logic [1:0]  m_op;
  logic [15:0] m_wd, m_din, m_dout;
  logic [31:0] m_rd;

  always @(posedge clk) begin
    int a;
    logic [31:0] rv;
    logic st;
    if (rst) begin
      m_req = 0; m_op = 0; m_wd = 0; m_din = 0; m_dout = 0; m_rd = 0;
    end else begin
      a = int'(bus_addr);
      rv = m_rd;
      if (bus_rd_en) begin
        if (a == 'h0C) rv = {16'h0, m_din};
        else if (a == 'h10) rv = {16'h0, m_dout};
        else if (a >= 'h14 && a <= 'h20 && (a % 4) == 0)
          rv = {31'h0, (m_req && int'(m_op) == (a - 'h14) / 4)};
        else rv = 32'h0;
      end
      st = bus_wr_en && bus_wdata[0] && !m_req &&
           (a == 'h14 || a == 'h18 || a == 'h1C || a == 'h20);
      if (m_req && cr_ack) begin
        m_req = 0;
        if (m_op == 2'd2) m_dout = cr_rdata;
      end
      if (st) begin
        m_req = 1;
        m_op = 2'((a - 'h14) / 4);
        m_wd = m_din;
      end
      if (bus_wr_en && a == 'h0C) m_din = bus_wdata[15:0];
      m_rd = rv;
    end
  end

  always @(posedge clk) begin
    #2;
    if (!rst) begin
      n_cmp++;
      if (cr_req !== m_req || bus_rdata !== m_rd ||
          (m_req && (cr_op !== m_op || cr_wdata !== m_wd))) begin
        n_bad++;
        $display("FAIL R4/R8/R9 cycle %0d: req=%b op=%0d wd=%h rd=%h expected req=%b op=%0d wd=%h rd=%h",
                 cyc, cr_req, cr_op, cr_wdata, bus_rdata, m_req, m_op, m_wd, m_rd);
      end
    end
  end

  // ---------------- Watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 60000) begin
      n_bad++;
      $display("FAIL watchdog: run hung, actual cycle %0d expected below 60000", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  // ---------------- Host tasks
  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bwrite(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_wr_en = 1'b1; bus_addr = 6'(a); bus_wdata = d;
    @(negedge clk);
    bus_wr_en = 1'b0;
  endtask

  task automatic bread(input int a, output logic [31:0] v);
    @(negedge clk);
    bus_rd_en = 1'b1; bus_addr = 6'(a);
    @(negedge clk);
    bus_rd_en = 1'b0;
    v = bus_rdata;
  endtask

  task automatic bcheck(input int a, input logic [31:0] exp, input string tag);
    logic [31:0] v;
    bread(a, v);
    check(tag, v, exp);
  endtask

  task automatic poll(input int a);
    logic [31:0] v;
    for (int i = 0; i < 40; i++) begin
      bread(a, v);
      if (v == 0) return;
    end
    check("R3 step never completed", v, 32'h0);
  endtask

  task automatic phy_write(input logic [15:0] ad, input logic [15:0] d);
    bwrite('h0C, {16'h0, ad}); bwrite('h14, 1); poll('h14);
    bwrite('h0C, {16'h0, d});  bwrite('h18, 1); poll('h18);
    bwrite('h20, 1); poll('h20);
  endtask

  task automatic phy_read(input logic [15:0] ad, output logic [31:0] v);
    bwrite('h0C, {16'h0, ad}); bwrite('h14, 1); poll('h14);
    bwrite('h1C, 1); poll('h1C);
    bread('h10, v);
  endtask

  initial begin
    logic [31:0] v, keep;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 cr_req after reset", {31'h0, cr_req}, 0);
    bcheck('h0C, 0, "R1 data-in");
    bcheck('h10, 0, "R1 data-out");
    bcheck('h14, 0, "R1 trigger addr");
    bcheck('h18, 0, "R1 trigger data");
    bcheck('h1C, 0, "R1 trigger read");
    bcheck('h20, 0, "R1 trigger write");

    // R2 data-in width
    bwrite('h0C, 32'hDEAD1234);
    bcheck('h0C, 32'h0000_1234, "R2 data-in readback");

    // R3/R7 full write then read sequences, lane 0 and lane 1
    phy_write(16'h1006, 16'h0B08);
    phy_write(16'h1002, 16'h4B7F);
    phy_write(16'h1106, 16'h0123);
    phy_read(16'h1006, v); check("R7 lane0 rx override", v, 32'h0B08);
    phy_read(16'h1002, v); check("R7 lane0 tx override", v, 32'h4B7F);
    phy_read(16'h1106, v); check("R7 lane1 rx override", v, 32'h0123);
    phy_read(16'h2002, v); check("R7 unwritten PHY reg", v, 32'h7A58);

    // R5 busy readback on the active trigger only
    lat_force = 5;
    bwrite('h1C, 1);
    bcheck('h1C, 1, "R5 active trigger busy");
    bcheck('h14, 0, "R5 other trigger idle");
    poll('h1C);
    bcheck('h1C, 0, "R5 trigger clear after ack");

    // R6 triggers during a busy step are dropped
    lat_force = 6;
    bwrite('h0C, 32'h1006);
    bwrite('h14, 1);
    bwrite('h20, 1);
    bwrite('h1C, 1);
    poll('h14);
    repeat (10) @(negedge clk);
    check("R6 no stray request", {31'h0, cr_req}, 0);
    lat_force = -1;
    phy_read(16'h1006, v); check("R6 PHY reg not rewritten", v, 32'h0B08);

    // R9 captured data survives a data-in rewrite
    lat_force = 6;
    bwrite('h0C, 32'h4444);
    bwrite('h18, 1);
    bwrite('h0C, 32'h5555);
    check("R9 held step data", {16'h0, cr_wdata}, 32'h4444);
    poll('h18);
    lat_force = -1;

    // R8 read-only, unmapped offsets
    bread('h10, keep);
    bwrite('h10, 32'hFFFF);
    bcheck('h10, keep, "R8 data-out not writable");
    bcheck('h3C, 0, "R8 unmapped high");
    bwrite('h00, 32'h7777);
    bcheck('h00, 0, "R8 unmapped low");
    bcheck('h0C, 32'h5555, "R8 unmapped write no effect");

    // R3 trigger with bit0 clear
    bwrite('h1C, 32'h2);
    repeat (3) @(negedge clk);
    check("R3 bit0 clear starts nothing", {31'h0, cr_req}, 0);

    // R7 more lanes with cycling latency
    for (int k = 0; k < 4; k++)
      phy_write(16'(16'h1002 + 16'h100 * k), 16'(16'h1111 * (k + 1)));
    for (int k = 0; k < 4; k++) begin
      phy_read(16'(16'h1002 + 16'h100 * k), v);
      check("R7 lane sweep", v, 32'(16'h1111 * (k + 1)));
    end

    repeat (4) @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule